// File: doc/BRIEF.md
# Power-Good Sequencer

This block decides when a switched supply may be reported healthy to the logic it feeds. It watches four conditions: a supply-voltage-ok flag, a digitised level code for the 5 V rail, a remote-off request that has already been delayed upstream, and a latched protection-fault status. The power-good output rises only after every condition has stayed valid for a long, programmed number of clock ticks. It falls at once, in the same cycle, when any condition fails. A remote-off request therefore pulls power-good down before the rails are actually switched off.

The rail check has hysteresis. The rail counts as qualified only once its code reaches an upper threshold `RAIL_HI`. After that it stays qualified until the code drops below a lower threshold `RAIL_LO`. A rail that sags into the band between the two thresholds does not disturb an established power-good. A rail that has not yet qualified must climb all the way to `RAIL_HI` before timing can start.

Control is a three-state machine:
- `ST_IDLE`: waiting for all conditions.
- `ST_WAIT`: the delay counter is running.
- `ST_GOOD`: power-good is being reported.

The transitions are:
- `go_wait` (`ST_IDLE` to `ST_WAIT`): all conditions are valid.
- `abort` (`ST_WAIT` to `ST_IDLE`): a condition fails during the count. The counter is cleared.
- `expire` (`ST_WAIT` to `ST_GOOD`): the count reaches its last value with conditions still valid.
- `drop` (`ST_GOOD` to `ST_IDLE`): a condition fails.

Top module: `pg_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no condition valid, `pwr_good` is 0 and the delay counter is zero.
- R2: `pwr_good` rises in the cycle after the clock edge at which the combined condition has been sampled valid on `DELAY_TICKS`+1 consecutive rising edges. The combined condition is: `vcc_ok`=1, `remote_off`=0, `fault_latched`=0 and the rail qualified.
- R3: When `rail_code` is below `RAIL_LO`, `pwr_good` is 0 in that same cycle, with no clock edge in between.
- R4: A rail that is not qualified becomes qualified only when `rail_code` is at or above `RAIL_HI`. A qualified rail stays qualified, and keeps `pwr_good` high, for any code from `RAIL_LO` up to `RAIL_HI`-1.
- R5: When `remote_off`=1, `pwr_good` is 0 in that same cycle, even while the rail is still in range.
- R6: When `fault_latched`=1, `pwr_good` is 0 in that same cycle.
- R7: When `vcc_ok`=0, `pwr_good` is 0 in that same cycle, and no delay is accumulated while it stays low.
- R8: Any edge that samples the combined condition invalid discards the accumulated count. After that, a full new delay of `DELAY_TICKS`+1 valid edges is needed before `pwr_good` can rise again, even if the failure lasted a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| vcc_ok | input | 1 | Supply-voltage detection is valid |
| rail_code | input | RAIL_W | Digitised 5 V rail level, larger means higher voltage |
| remote_off | input | 1 | Delayed remote shutdown request, 1 = off |
| fault_latched | input | 1 | Latched over/under-voltage protection status |
| pwr_good | output | 1 | Power-good indication |

## Verification
An extra count of one, or a counter that is not cleared on an abort, shows up as `pwr_good` rising a cycle early or without a full restart. A per-cycle reference catches this on the very edge where the rise happens. A rail-qualification flag stuck in the wrong state shows up as power-good either held through a sag below `RAIL_LO`, or restarted from a code inside the hysteresis band. Either case is visible within one cycle of the rail stimulus. Every trigger that should drop the output is applied while `ST_GOOD` is active, so a missing same-cycle gate appears as a high output on the first compare after the trigger.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GOOD = 2'd2
    } pg_state_t;

endpackage

// File: rtl/pg_rail_hyst.sv
// Rail qualification with hysteresis: qualify at or above HI, lose below LO.
module pg_rail_hyst #(
    parameter int RAIL_W  = 8,
    parameter int RAIL_HI = 180,
    parameter int RAIL_LO = 172
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAIL_W-1:0] rail_code,
    output logic              rail_ok,
    output logic              rail_below
);
    localparam logic [RAIL_W-1:0] HI_C = RAIL_W'(RAIL_HI);
    localparam logic [RAIL_W-1:0] LO_C = RAIL_W'(RAIL_LO);

    logic qual_q;
    logic above_hi;

    always_comb begin
        above_hi   = (rail_code >= HI_C);
        rail_below = (rail_code < LO_C);
        rail_ok    = above_hi | (qual_q & ~rail_below);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= rail_ok;
    end
endmodule

// File: rtl/pg_delay_timer.sv
// Tick counter with synchronous clear; done marks the last count value.
module pg_delay_timer #(
    parameter int DELAY_TICKS = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
    import pg_seq_pkg::*;
#(
    parameter int RAIL_W      = 8,
    parameter int RAIL_HI     = 180,
    parameter int RAIL_LO     = 172,
    parameter int DELAY_TICKS = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_ok,
    input  logic [RAIL_W-1:0] rail_code,
    input  logic              remote_off,
    input  logic              fault_latched,
    output logic              pwr_good
);
    pg_state_t state_q, state_d;
    logic      rail_ok, rail_below;
    logic      all_ok;
    logic      tmr_clr, tmr_en, tmr_done;

    pg_rail_hyst #(
        .RAIL_W (RAIL_W),
        .RAIL_HI(RAIL_HI),
        .RAIL_LO(RAIL_LO)
    ) u_rail (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_code (rail_code),
        .rail_ok   (rail_ok),
        .rail_below(rail_below)
    );

    pg_delay_timer #(
        .DELAY_TICKS(DELAY_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .done (tmr_done)
    );

    // Combined condition; any failing term drops power-good this cycle.
    assign all_ok = vcc_ok & ~remote_off & ~fault_latched & rail_ok & ~rail_below;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (all_ok) state_d = ST_WAIT;           // go_wait
            ST_WAIT: begin
                if (!all_ok)        state_d = ST_IDLE;         // abort
                else if (tmr_done)  state_d = ST_GOOD;         // expire
            end
            ST_GOOD: if (!all_ok) state_d = ST_IDLE;           // drop
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and timer control
    always_comb begin
        tmr_clr  = 1'b1;
        tmr_en   = 1'b0;
        pwr_good = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                tmr_clr = ~all_ok;
                tmr_en  = all_ok & ~tmr_done;
            end
            ST_GOOD: pwr_good = all_ok;
            default: ;
        endcase
    end
endmodule

// File: rtl/pg_sequencer_chk.sv
module pg_sequencer_chk #(
    parameter int RAIL_W      = 8,
    parameter int RAIL_LO     = 172,
    parameter int DELAY_TICKS = 12_500_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vcc_ok,
    input logic [RAIL_W-1:0] rail_code,
    input logic              remote_off,
    input logic              fault_latched,
    input logic              pwr_good
);
    // Necessary-condition run length, saturating.
    logic        need_ok;
    logic [31:0] run_c;

    assign need_ok = vcc_ok & ~remote_off & ~fault_latched & (rail_code >= RAIL_W'(RAIL_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_c <= '0;
        else if (!need_ok)          run_c <= '0;
        else if (run_c != '1)       run_c <= run_c + 1'b1;
    end

    a_r3_rail_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_code < RAIL_W'(RAIL_LO)) |-> !pwr_good);

    a_r5_remote_drops: assert property (@(posedge clk) disable iff (!rst_n)
        remote_off |-> !pwr_good);

    a_r6_fault_drops: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> !pwr_good);

    a_r7_vcc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |-> !pwr_good);

    // R2 and R8: high output needs a full uninterrupted window.
    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (run_c > 32'(DELAY_TICKS)));

    a_r8_rise_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> $past(need_ok));
endmodule

bind pg_sequencer pg_sequencer_chk #(
    .RAIL_W     (RAIL_W),
    .RAIL_LO    (RAIL_LO),
    .DELAY_TICKS(DELAY_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_ok       (vcc_ok),
    .rail_code    (rail_code),
    .remote_off   (remote_off),
    .fault_latched(fault_latched),
    .pwr_good     (pwr_good)
);

// File: tb/pg_sequencer_tb.sv
`timescale 1ns/1ps
module pg_sequencer_tb;
    localparam int W  = 8;
    localparam int HI = 180;
    localparam int LO = 172;
    localparam int N  = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vcc_ok = 1'b0;
    logic [W-1:0] rail_code = '0;
    logic         remote_off = 1'b1;
    logic         fault_latched = 1'b0;
    logic         pwr_good;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done_flag = 1'b0;

    // Reference model state
    int m_run = 0;
    bit m_qual = 1'b0;

    always #10 clk = ~clk;

    pg_sequencer #(
        .RAIL_W(W), .RAIL_HI(HI), .RAIL_LO(LO), .DELAY_TICKS(N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .rail_code(rail_code),
        .remote_off(remote_off), .fault_latched(fault_latched), .pwr_good(pwr_good)
    );

    function automatic bit rail_now();
        return (int'(rail_code) >= HI) || (m_qual && int'(rail_code) >= LO);
    endfunction

    function automatic bit ok_now();
        return vcc_ok && !remote_off && !fault_latched && rail_now();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run  = 0;
            m_qual = 1'b0;
        end else begin
            bit ok_s, rq;
            ok_s = ok_now();
            rq   = rail_now();
            m_run  = ok_s ? m_run + 1 : 0;
            m_qual = rq;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done_flag) begin
            bit exp_pg;
            exp_pg = rst_n && (m_run >= N + 1) && ok_now();
            n_cmp++;
            if (pwr_good !== exp_pg) begin
                n_bad++;
                $display("FAIL %s t=%0t pwr_good actual=%b expected=%b", cur_req, $time, pwr_good, exp_pg);
            end
        end
    end

    task automatic drive(input bit v, input int code, input bit rem, input bit flt);
        @(posedge clk);
        #1;
        vcc_ok = v; rail_code = W'(code); remote_off = rem; fault_latched = flt;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Point check at the ports, named by requirement.
    task automatic expect_pg(input bit e, input string req);
        @(negedge clk);
        #1;
        n_cmp++;
        if (pwr_good !== e) begin
            n_bad++;
            $display("FAIL %s point check pwr_good actual=%b expected=%b", req, pwr_good, e);
        end
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        wait_cyc(3);
        expect_pg(1'b0, "R1");
        rst_n = 1'b1;
        wait_cyc(3);
        expect_pg(1'b0, "R1");

        // R2: clean power-up, exact delay
        cur_req = "R2";
        drive(1, 200, 0, 0);
        wait_cyc(N);
        expect_pg(1'b0, "R2");
        wait_cyc(2);
        expect_pg(1'b1, "R2");

        // R4: sag into the band keeps power-good
        cur_req = "R4";
        drive(1, 175, 0, 0);
        wait_cyc(5);
        expect_pg(1'b1, "R4");

        // R3: below low threshold drops immediately
        cur_req = "R3";
        drive(1, 171, 0, 0);
        expect_pg(1'b0, "R3");

        // R4: rising only into the band does not restart timing
        cur_req = "R4";
        drive(1, 179, 0, 0);
        wait_cyc(N + 5);
        expect_pg(1'b0, "R4");
        drive(1, 180, 0, 0);
        wait_cyc(N + 3);
        expect_pg(1'b1, "R4");

        // R5: one-cycle remote-off drops and forces a full new delay (R8)
        cur_req = "R5";
        drive(1, 200, 1, 0);
        expect_pg(1'b0, "R5");
        cur_req = "R8";
        drive(1, 200, 0, 0);
        wait_cyc(N - 1);
        expect_pg(1'b0, "R8");
        wait_cyc(3);
        expect_pg(1'b1, "R8");

        // R6: fault
        cur_req = "R6";
        drive(1, 200, 0, 1);
        expect_pg(1'b0, "R6");
        wait_cyc(4);
        drive(1, 200, 0, 0);

        // R8: glitch just before expiry restarts the count
        cur_req = "R8";
        wait_cyc(N - 2);
        drive(0, 200, 0, 0);
        drive(1, 200, 0, 0);
        wait_cyc(N - 1);
        expect_pg(1'b0, "R8");
        wait_cyc(3);
        expect_pg(1'b1, "R8");

        // R7: supply flag low
        cur_req = "R7";
        drive(0, 200, 0, 0);
        expect_pg(1'b0, "R7");
        wait_cyc(N + 5);
        expect_pg(1'b0, "R7");
        drive(1, 200, 0, 0);
        wait_cyc(N + 3);
        expect_pg(1'b1, "R7");

        // R1: reset mid-operation
        cur_req = "R1";
        rst_n = 1'b0;
        expect_pg(1'b0, "R1");
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(N + 4);
        expect_pg(1'b1, "R1");

        wait_cyc(3);
        finish_run();
    end
endmodule